// File: doc/BRIEF.md
# Eight-Bit Multicycle Register Processor

This block is a compact 8-bit processor that runs a program of single-byte instructions held in one external memory. Each instruction takes four or five clock cycles: a two-cycle fetch that latches the instruction byte and advances the program counter, a decode cycle that copies operands into holding registers, and one or two cycles that finish the work. These finishing cycles compute a result, take a branch, or drive an address and then complete the memory transfer. Sequencing comes from a Moore state machine. The program counter has its own incrementer, so the ALU never computes PC+1.

The processor has eight 8-bit general registers. Arithmetic and logic instructions always take register 1 as their second operand. A load-immediate instruction reads the byte after its opcode and steps over it. A jump-and-link reads its target from a register and then writes the return address back into that same register. The memory is attached through an 8-bit address bus, a shared bidirectional 8-bit data bus and separate read and write strobes. The surrounding system supplies the memory and keeps its read latency within one clock.

Top module: `byte_cpu`

## Requirements
- R1: While reset is active, and in the first cycle after it is released, the processor drives address 0x00 with the read strobe high and the write strobe low. Reset clears both flags, so a BRZ or BRN that runs before any ALU instruction is not taken.
- R2: An instruction fetch takes two cycles with the read strobe high. The address is held constant across both cycles, and the byte is sampled at the end of the second cycle. A load or a load-immediate reads memory in the same two-cycle way.
- R3: The instruction byte is split into bits [7:6] (class), [5:3] (field A) and [2:0] (field B). Class 00 is MOV and copies register A into register B. Class 01 is LD and loads register B from memory at the address held in register A. Class 10 is ST and writes register B to memory at the address held in register A.
- R4: In class 11, field A is the operation and field B names register B. Operation 000 computes B AND R1, 001 computes B + R1 and 010 computes B − R1, each modulo 256, and writes the result into register B.
- R5: Only AND, ADD and SUB change the flags. Z is set when the 8-bit result is zero, and N is set when result bit 7 is 1. MOV, LD, ST, LDI and all branch and jump instructions leave Z and N unchanged.
- R6: Operation 011 (BR) always loads the PC from register B. Operation 100 (BRZ) does so only when Z=1, and 101 (BRN) only when N=1. An untaken branch continues at the next byte.
- R7: Operation 110 (JAL) loads the PC from the old value of register B and writes the address of the following instruction into register B.
- R8: Operation 111 (LDI) loads register B from the byte that follows the opcode and resumes two bytes after the opcode. All addresses wrap modulo 256, so an LDI at 0xFF takes its data from 0x00.
- R9: The processor drives the data bus only while the write strobe is high. The write strobe lasts one cycle, is never high at the same time as the read strobe, and its address is already on the bus one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | 8 | Memory address |
| mem_data | inout | 8 | Shared data bus; driven by the processor only during a write |
| mem_rd | output | 1 | Read strobe; memory must drive the bus while it is high |
| mem_wr | output | 1 | Write strobe; memory captures the bus at the rising edge |

## Verification
The embedded properties assume a memory that places valid data on the bus within the cycle after the address appears. They also assume the memory releases the bus whenever the read strobe is low. The bench memory model drives the bus combinationally from its array only while the read strobe is high, and it captures writes on the clock edge, so it stays inside these assumptions. Programs in the bench first set every register they read with LDI, and the bench observes register contents only through ST to scratch addresses. It observes flags only through branches that pick which marker value gets stored.

// File: rtl/byte_cpu.sv
module byte_cpu #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [DW-1:0] mem_addr,
  inout  wire  [DW-1:0] mem_data,
  output logic          mem_rd,
  output logic          mem_wr
);
  localparam int NREG = 8;

  typedef enum logic [3:0] {
    S_FA, S_FD, S_DEC, S_ALU, S_WB, S_LDA, S_LDD,
    S_STA, S_STW, S_BR, S_JAL, S_LIA, S_LID
  } st_t;

  st_t st;
  logic [DW-1:0] pc, opa, opb, res, alu_y;
  logic [DW-1:0] rf [NREG];
  logic [7:0]    ir;
  logic          zf, nf;

  wire [1:0]    cls = ir[7:6];
  wire [2:0]    fa  = ir[5:3];
  wire [2:0]    fb  = ir[2:0];
  wire          ext = (cls == 2'b11);
  wire [DW-1:0] pc_inc = pc + {{(DW-1){1'b0}}, 1'b1};
  wire          alu_flag = ext && (fa <= 3'd2);
  wire          taken = (fa == 3'd3) || (fa == 3'd4 && zf) || (fa == 3'd5 && nf);

  assign mem_addr = (st inside {S_LDA, S_LDD, S_STA, S_STW}) ? opa : pc;
  assign mem_rd   = st inside {S_FA, S_FD, S_LDA, S_LDD, S_LIA, S_LID};
  assign mem_wr   = (st == S_STW);
  assign mem_data = mem_wr ? opb : 'z;

  always_comb begin
    alu_y = opa;
    if (ext)
      case (fa)
        3'd0:    alu_y = opb & opa;
        3'd1:    alu_y = opb + opa;
        3'd2:    alu_y = opb - opa;
        default: alu_y = opb;
      endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_FA;
      pc  <= '0;
      ir  <= '0;
      opa <= '0;
      opb <= '0;
      res <= '0;
      zf  <= 1'b0;
      nf  <= 1'b0;
    end else begin
      case (st)
        S_FA: st <= S_FD;
        S_FD: begin
          ir <= mem_data[7:0];
          pc <= pc_inc;
          st <= S_DEC;
        end
        S_DEC: begin
          opa <= ext ? rf[1] : rf[fa];
          opb <= rf[fb];
          case (cls)
            2'b00: st <= S_ALU;
            2'b01: st <= S_LDA;
            2'b10: st <= S_STA;
            default: st <= (fa <= 3'd2) ? S_ALU :
                           (fa == 3'd6) ? S_JAL :
                           (fa == 3'd7) ? S_LIA : S_BR;
          endcase
        end
        S_ALU: begin
          res <= alu_y;
          if (alu_flag) begin
            zf <= (alu_y == '0);
            nf <= alu_y[DW-1];
          end
          st <= S_WB;
        end
        S_LDA: st <= S_LDD;
        S_STA: st <= S_STW;
        S_LIA: st <= S_LID;
        S_BR: begin
          if (taken) pc <= opb;
          st <= S_FA;
        end
        S_JAL: begin
          pc <= opb;
          st <= S_FA;
        end
        S_LID: begin
          pc <= pc_inc;
          st <= S_FA;
        end
        default: st <= S_FA;
      endcase
    end
  end

  logic          rf_we;
  logic [DW-1:0] rf_wd;
  always_comb begin
    rf_we = 1'b1;
    rf_wd = res;
    case (st)
      S_WB:         rf_wd = res;
      S_LDD, S_LID: rf_wd = mem_data;
      S_JAL:        rf_wd = pc;
      default:      rf_we = 1'b0;
    endcase
  end

  always_ff @(posedge clk)
    if (rf_we) rf[fb] <= rf_wd;

  p_fetch_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FD) |-> ($stable(mem_addr) && $past(mem_rd)));
  p_wr_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> !mem_rd);
  p_wr_addr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> $stable(mem_addr));
  p_wr_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> !mem_wr);
  p_flags_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_ALU) |=> $stable({zf, nf}));
  p_jal_target_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_JAL) |=> (pc == $past(opb)));
  p_ldi_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_LID) |=> (pc == $past(pc_inc)));
endmodule

// File: tb/byte_cpu_tb.sv
`timescale 1ns/1ps
module byte_cpu_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] mem_addr;
  wire  [7:0] bus;
  logic       mem_rd, mem_wr;
  logic [7:0] mem [256];
  int checks = 0, failures = 0, viol = 0, ptr = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  byte_cpu u_dut (.clk(clk), .rst_n(rst_n), .mem_addr(mem_addr),
                  .mem_data(bus), .mem_rd(mem_rd), .mem_wr(mem_wr));

  assign bus = mem_rd ? mem[mem_addr] : 8'hzz;
  always @(posedge clk) if (mem_wr) mem[mem_addr] <= bus;

  always @(negedge clk)
    if (rst_n) begin
      if (mem_wr && mem_rd) viol++;
      if (!mem_rd && !mem_wr && bus !== 8'hzz) viol++;
    end

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic e(input logic [7:0] b);
    mem[ptr[7:0]] = b;
    ptr++;
  endtask
  task automatic ldi(input logic [2:0] r, input logic [7:0] v);
    e({5'b11111, r}); e(v);
  endtask
  task automatic st(input logic [2:0] ra, input logic [2:0] rb);
    e({2'b10, ra, rb});
  endtask
  task automatic xop(input logic [2:0] op, input logic [2:0] r);
    e({2'b11, op, r});
  endtask
  task automatic mark(input logic [7:0] a, input logic [7:0] v, input logic [7:0] tgt);
    ldi(3'd3, v); ldi(3'd4, a); st(3'd4, 3'd3); ldi(3'd6, tgt); xop(3'd3, 3'd6);
  endtask
  task automatic halt_at(input int a);
    ptr = a; ldi(3'd7, a[7:0]); xop(3'd3, 3'd7);
  endtask
  task automatic begin_prog();
    rst_n = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    ptr = 0;
  endtask
  task automatic run(input int n);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] vals [9] = '{8'h00, 8'h01, 8'h05, 8'h06, 8'h7f, 8'h80, 8'hff, 8'haa, 8'h55};
    logic [7:0] r;

    // R1 priming: leave N set, then reset
    begin_prog();
    ldi(3'd1, 8'h01); ldi(3'd2, 8'h00); xop(3'd2, 3'd2); halt_at(8);
    run(60);
    begin_prog();
    ldi(3'd6, 8'h20); xop(3'd4, 3'd6); xop(3'd5, 3'd6); mark(8'hf0, 8'h11, 8'h60);
    ptr = 'h20; mark(8'hf0, 8'h22, 8'h60);
    halt_at('h60);
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1 reset addr", mem_addr, 8'h00);
    chk("R1 reset rd", {7'd0, mem_rd}, 8'h01);
    chk("R1 reset wr", {7'd0, mem_wr}, 8'h00);
    rst_n = 1'b1;
    chk("R2 fetch cycle0 addr", mem_addr, 8'h00);
    @(posedge clk); @(negedge clk);
    chk("R2 fetch cycle1 addr", mem_addr, 8'h00);
    chk("R2 fetch cycle1 rd", {7'd0, mem_rd}, 8'h01);
    @(posedge clk); @(negedge clk);
    chk("R2 decode rd low", {7'd0, mem_rd}, 8'h00);
    @(posedge clk); @(negedge clk);
    chk("R8 immediate addr", mem_addr, 8'h01);
    repeat (120) @(posedge clk);
    @(negedge clk);
    chk("R1 flags clear after reset", mem[8'hf0], 8'h11);

    // R3 MOV and LD
    begin_prog();
    mem[8'h80] = 8'h9d;
    ldi(3'd1, 8'h3c); e({2'b00, 3'd1, 3'd5}); ldi(3'd4, 8'hf0); st(3'd4, 3'd5);
    ldi(3'd2, 8'h80); e({2'b01, 3'd2, 3'd3}); ldi(3'd4, 8'hf1); st(3'd4, 3'd3);
    halt_at(ptr);
    run(120);
    chk("R3 MOV", mem[8'hf0], 8'h3c);
    chk("R3 LD", mem[8'hf1], 8'h9d);
    chk("R3 ST no stray write", mem[8'hf2], 8'h00);

    // R7 JAL
    begin_prog();
    ldi(3'd5, 8'h40); xop(3'd6, 3'd5); halt_at(3);
    ptr = 'h40; ldi(3'd4, 8'hf0); st(3'd4, 3'd5); halt_at('h44);
    run(80);
    chk("R7 JAL link", mem[8'hf0], 8'h03);

    // R8 LDI wrap at 0xFF
    begin_prog();
    mem[0] = 8'hfe; mem[1] = 8'hff; mem[2] = 8'hde; mem[8'hff] = 8'hfa;
    ptr = 3;
    ldi(3'd4, 8'hf0); st(3'd4, 3'd2); ldi(3'd4, 8'hf1); st(3'd4, 3'd7);
    halt_at(ptr);
    run(100);
    chk("R8 LDI wrap data", mem[8'hf0], 8'hfe);
    chk("R8 LDI step", mem[8'hf1], 8'hde);

    // R4 R5 R6 sweep over AND/ADD/SUB
    for (int op = 0; op < 3; op++)
      for (int i = 0; i < 9; i++)
        for (int j = 0; j < 9; j++) begin
          begin_prog();
          ldi(3'd1, vals[i]); ldi(3'd2, vals[j]); xop(op[2:0], 3'd2);
          ldi(3'd4, 8'hf0); st(3'd4, 3'd2);
          ldi(3'd6, 8'h20); xop(3'd4, 3'd6); mark(8'hf1, 8'h00, 8'h30);
          ptr = 'h20; mark(8'hf1, 8'h01, 8'h30);
          ptr = 'h30; ldi(3'd6, 8'h50); xop(3'd5, 3'd6); mark(8'hf2, 8'h00, 8'h60);
          ptr = 'h50; mark(8'hf2, 8'h01, 8'h60);
          halt_at('h60);
          run(200);
          r = (op == 0) ? (vals[j] & vals[i]) :
              (op == 1) ? (vals[j] + vals[i]) : (vals[j] - vals[i]);
          chk("R4 ALU result", mem[8'hf0], r);
          chk("R5 R6 Z via BRZ", mem[8'hf1], {7'd0, r == 8'h00});
          chk("R5 R6 N via BRN", mem[8'hf2], {7'd0, r[7]});
        end

    chk("R9 bus discipline violations", viol[7:0], 8'h00);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule